// File: doc/BRIEF.md
# RAS Hold Timeout and Precharge Guard

This block sits beside a DRAM cycle sequencer. It measures how long the row strobe of the currently open bank has been held low. When that time passes a programmed limit, it asks the sequencer to close the page. The sequencer then drives RAS high at a safe point. The close request never cuts into a memory access. It is raised only when no access is in progress, and only on the clock that marks the middle of a T-state. The sequencer therefore drops RAS in the middle of the first T-state after the running cycle ends.

After a close, the block holds a precharge-busy flag for the closed bank for a fixed number of clocks, four by default. The sequencer reads this flag when it plans the next access. If the flag is set for the target bank, it must use a page-miss or bank-switch sequence that meets the minimum RAS high time. Banks whose flag is clear follow ordinary bank-switch timing.

The limit is an input count of clock cycles. It is derived from the clock rate; at 33 MHz, the nominal 9.5 us is about 314 cycles. The feature has an enable input.

Top module: `ras_timeout_guard`

## Requirements
- R1: While reset is held, and right after it, `close_req` is 0, `close_bank` is all zeros and `pre_busy` is all zeros.
- R2: While `tmo_en` is 0, `close_req` stays 0 whatever the other inputs do.
- R3: Bit i of `ras_low` set means bank i has RAS asserted. A close becomes possible only after the same nonzero `ras_low` pattern has been sampled on `tmo_limit` consecutive rising edges. Any change of the pattern, or all-zero, restarts the count.
- R4: `close_req` is 0 in any cycle where `cycle_busy` is 1, so an access in progress is always allowed to finish first.
- R5: `close_req` is raised only in a cycle where `tstate_mid` is 1. `tstate_mid` marks the middle of a T-state.
- R6: When `close_req` is 1, `close_bank` equals the one-hot `ras_low` of the open bank. At all other times `close_bank` is zero.
- R7: A close on bank i sets `pre_busy[i]` on the next rising edge. The flag stays set for exactly PRE_CLKS (4) sampled cycles and then clears.
- R8: A close touches only the `pre_busy` bit of the closed bank. The flags of all other banks stay 0, so those banks keep normal bank-switch timing.
- R9: With no bank open (`ras_low` all zero), `close_req` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_en | input | 1 | Enables the timeout |
| tmo_limit | input | CNT_W | Timeout length in clock cycles (at least 1) |
| ras_low | input | NB | One-hot asserted-RAS bank, all zero when no page is open |
| cycle_busy | input | 1 | A memory access is in progress |
| tstate_mid | input | 1 | This clock is the middle of a T-state |
| close_req | output | 1 | Sequencer must drive the open bank's RAS high now |
| close_bank | output | NB | One-hot bank being closed |
| pre_busy | output | NB | Per-bank minimum-RAS-high guard active |

## Verification
The expiry of the timeout and the gating by an access in progress and by the T-state midpoint can all fall in the same cycle. The bench lets the count expire while `cycle_busy` and `tstate_mid` are both high, and checks that no close comes out. It then drops `cycle_busy` with `tstate_mid` low and checks again, and finally raises `tstate_mid` alone. The close must come out exactly on that third step. The bench then checks that the per-bank guard starts on the next edge for the closed bank only.

// File: rtl/ras_timeout_guard.sv
module ras_timeout_guard #(
  parameter int NB       = 4,
  parameter int CNT_W    = 10,
  parameter int PRE_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_en,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic [NB-1:0]    ras_low,
  input  logic             cycle_busy,
  input  logic             tstate_mid,
  output logic             close_req,
  output logic [NB-1:0]    close_bank,
  output logic [NB-1:0]    pre_busy
);
  localparam int PW = $clog2(PRE_CLKS + 1);

  logic [NB-1:0]    ras_q;
  logic [CNT_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= '0;
      held  <= '0;
    end else begin
      ras_q <= ras_low;
      if (ras_low == '0)         held <= '0;
      else if (ras_low != ras_q) held <= CNT_W'(1);
      else if (held != '1)       held <= held + 1'b1;
    end
  end

  wire expired = (|ras_low) && (ras_low == ras_q) && (held >= tmo_limit);

  assign close_req  = tmo_en && expired && !cycle_busy && tstate_mid;
  assign close_bank = close_req ? ras_low : '0;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [PW-1:0] left;
    always_ff @(posedge clk) begin
      if (!rst_n)             left <= '0;
      else if (close_bank[b]) left <= PW'(PRE_CLKS);
      else if (left != '0)    left <= left - 1'b1;
    end
    assign pre_busy[b] = (left != '0);
  end
endmodule

module ras_timeout_guard_chk #(
  parameter int NB    = 4,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmo_en,
  input logic [NB-1:0]    ras_low,
  input logic             cycle_busy,
  input logic             tstate_mid,
  input logic             close_req,
  input logic [NB-1:0]    close_bank,
  input logic [NB-1:0]    pre_busy
);
  assert_off_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |-> !close_req);

  assert_waits_for_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_busy |-> !close_req);

  assert_mid_tstate_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    close_req |-> tstate_mid);

  assert_bank_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    close_req |-> ($onehot(close_bank) && close_bank == ras_low));

  assert_no_page_no_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_low == '0) |-> !close_req);

  assert_guard_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    close_req |=> ((pre_busy & $past(close_bank)) == $past(close_bank)));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    assert_guard_own_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pre_busy[i]) |-> $past(close_bank[i]));
  end
endmodule

bind ras_timeout_guard ras_timeout_guard_chk #(.NB(NB), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .ras_low(ras_low),
  .cycle_busy(cycle_busy), .tstate_mid(tstate_mid), .close_req(close_req),
  .close_bank(close_bank), .pre_busy(pre_busy)
);

// File: tb/ras_timeout_guard_test.sv
`timescale 1ns/1ps
module ras_timeout_guard_test;
  localparam int NB = 4, CNT_W = 10;

  logic clk = 0, rst_n = 0, tmo_en = 0, cycle_busy = 0, tstate_mid = 0;
  logic [CNT_W-1:0] tmo_limit = '0;
  logic [NB-1:0] ras_low = '0;
  logic close_req;
  logic [NB-1:0] close_bank, pre_busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ras_timeout_guard #(.NB(NB), .CNT_W(CNT_W), .PRE_CLKS(4)) uut (
    .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .tmo_limit(tmo_limit),
    .ras_low(ras_low), .cycle_busy(cycle_busy), .tstate_mid(tstate_mid),
    .close_req(close_req), .close_bank(close_bank), .pre_busy(pre_busy));

  // {en, limit[7:0], bank[3:0], hold[7:0], expect_close}
  localparam logic [21:0] VEC [8] = '{
    {1'b1, 8'd5, 4'b0001, 8'd5,  1'b1},
    {1'b1, 8'd5, 4'b0010, 8'd4,  1'b0},
    {1'b1, 8'd3, 4'b0100, 8'd10, 1'b1},
    {1'b0, 8'd3, 4'b1000, 8'd10, 1'b0},
    {1'b1, 8'd3, 4'b0000, 8'd10, 1'b0},
    {1'b1, 8'd1, 4'b1000, 8'd1,  1'b1},
    {1'b1, 8'd8, 4'b0010, 8'd8,  1'b1},
    {1'b1, 8'd8, 4'b0001, 8'd7,  1'b0}
  };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk(!close_req && close_bank == '0 && pre_busy == '0, "R1 reset",
        {close_req, close_bank, pre_busy}, 0);
    rst_n = 1;
    tick(1);
    @(negedge clk);
    chk(!close_req && pre_busy == '0, "R1 after reset", {close_req, pre_busy}, 0);

    for (int v = 0; v < 8; v++) begin
      logic [21:0] e;
      logic [3:0] bank;
      e = VEC[v];
      bank = e[12:9];
      tick(1);
      tmo_en = e[21]; tmo_limit = CNT_W'(e[20:13]); ras_low = bank;
      tick(int'(e[8:1]));
      tstate_mid = 1;
      @(negedge clk);
      // R2, R3, R9: close_req only when enabled, page open and count reached
      chk(close_req == e[0], "R3/R2/R9 close_req", close_req, e[0]);
      chk(close_bank == (e[0] ? bank : 4'b0), "R6 close_bank", close_bank,
          e[0] ? bank : 4'b0);
      tick(1);
      tstate_mid = 0; ras_low = '0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(pre_busy == (e[0] ? bank : 4'b0), "R7/R8 pre_busy held", pre_busy,
            e[0] ? bank : 4'b0);
        tick(1);
      end
      @(negedge clk);
      chk(pre_busy == '0, "R7 pre_busy cleared", pre_busy, 0);
    end

    // R4/R5: expiry, busy and midpoint all in one cycle
    tmo_en = 1; tmo_limit = 2; ras_low = 4'b0001;
    tick(4);
    cycle_busy = 1; tstate_mid = 1;
    @(negedge clk);
    chk(!close_req, "R4 busy blocks close", close_req, 0);
    tick(1);
    cycle_busy = 0; tstate_mid = 0;
    @(negedge clk);
    chk(!close_req, "R5 waits for midpoint", close_req, 0);
    tick(1);
    tstate_mid = 1;
    @(negedge clk);
    chk(close_req && close_bank == 4'b0001, "R5 close at midpoint",
        {close_req, close_bank}, 5'h11);
    tick(1);
    tstate_mid = 0; ras_low = '0;
    @(negedge clk);
    chk(pre_busy == 4'b0001, "R7 guard after midpoint close", pre_busy, 1);
    tick(6);

    // R3: bank change restarts the count
    tmo_limit = 4; ras_low = 4'b0001;
    tick(3);
    ras_low = 4'b0010;
    tick(1);
    tstate_mid = 1;
    @(negedge clk);
    chk(!close_req, "R3 restart on bank change", close_req, 0);
    tick(3);
    @(negedge clk);
    chk(close_req && close_bank == 4'b0010, "R3 expiry after restart",
        {close_req, close_bank}, 5'h12);
    tick(1);
    tstate_mid = 0; ras_low = '0;
    @(negedge clk);
    chk(pre_busy == 4'b0010, "R8 only closed bank guarded", pre_busy, 2);

    // R1: reset during precharge clears the guard
    rst_n = 0;
    tick(1);
    @(negedge clk);
    chk(pre_busy == '0 && !close_req, "R1 reset clears guard", pre_busy, 0);
    rst_n = 1;

    done = 1;
    summary();
  end
endmodule